// File: doc/BRIEF.md
# Time-Shared Address/Data Bus Segment

This block is one segment of a parallel bus. The same set of lines carries the address of a transfer and then its data, one after the other. A small bus master inside the segment takes one request at a time from its user port. It spends one clock on an address phase, with an address-valid strobe high and the command line showing read or write. It then spends one clock on a data phase, with a data-valid strobe high. Two targets sit on the lines. The first is a memory module of 128 words that fills the lower half of the address space. The second is an I/O module with a small set of registers in the upper half. Both targets capture the address during the address phase and decide on their own whether they are being addressed.

During a write data phase the master drives the lines. During a read data phase only the addressed target drives them, and the master captures the value. Each driver has an output enable, and the line resolver combines them. When nothing drives the lines they read as zero. This zero is also the value returned for an upper-half address that has no register behind it.

Top module: `muxbus_segment`

## Requirements
- R1: While reset is held and after it is released, address-valid, data-valid and the response valid are low, the bus lines read 0x00, and the request port is ready.
- R2: A request accepted at a clock edge puts that address on the bus lines, with address-valid high for exactly one cycle, in the following cycle. The command line equals the request's write flag in that cycle (1 = write).
- R3: Data-valid is high for exactly the one cycle after each address-valid cycle, and the two strobes are never high together.
- R4: In the data phase of a write, the bus lines carry the request's write data.
- R5: An address with bit 7 clear selects the memory. A read returns the last value written to that word: the value is on the lines during the data phase, and the response valid and response data appear in the next cycle.
- R6: An address with bit 7 set selects the I/O module, whose registers sit at 0x80 to 0x83 (for IO_REGS = 4). They are separate from memory, so a write to 0x81 does not change memory word 0x01.
- R7: An upper-half address beyond the last I/O register has no target. A read of it returns 0x00, and a write to it changes no register.
- R8: Outside the two phases the bus lines read 0x00, and at most one driver enables its output in any cycle.
- R9: The request port is not ready only during an address phase. A request held during that phase is ignored. A request accepted during a data phase starts its address phase in the very next cycle.
- R10: Every I/O register reads 0x00 after reset until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request taken at this edge if valid |
| rsp_valid | output | 1 | Read result valid (one cycle) |
| rsp_rdata | output | DW | Read result |
| bus_lines | output | DW | Resolved shared address/data lines |
| bus_ale | output | 1 | Address-valid strobe |
| bus_dstb | output | 1 | Data-valid strobe |
| bus_cmd_write | output | 1 | Command line, valid with address-valid |

## Verification
The properties assume that the request inputs are stable around each clock edge. They also assume that the memory is read only at words written since power-up, because the memory array has no reset. The stimulus changes inputs only on falling edges and keeps a record of which memory words have been written. A random read aimed at an unwritten word is turned into a write to that word. Requests are sometimes held through the address phase to exercise the ignored case, and are sometimes issued with idle gaps between them.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // Lower half of the address space belongs to the memory module.
  function automatic logic addr_is_memory(input logic [15:0] a, input int aw);
    return (a[aw-1] == 1'b0);
  endfunction

  // Upper half: a register exists only for offsets below nregs.
  function automatic logic addr_is_io(input logic [15:0] a, input int aw, input int nregs);
    logic [15:0] off;
    off = a & ((16'd1 << (aw - 1)) - 16'd1);
    return (a[aw-1] == 1'b1) && (int'(off) < nregs);
  endfunction

endpackage

// File: rtl/muxbus_master.sv
module muxbus_master #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic [DW-1:0] lines_in,
  output logic          drv_oe,
  output logic [DW-1:0] drv_data,
  output logic          ale,
  output logic          dstb,
  output logic          cmd_write
);
  import muxbus_pkg::*;

  phase_e        ph_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          wr_q;
  logic          accept;

  assign req_ready = (ph_q != PH_ADDR);
  assign accept    = req_valid && req_ready;
  assign ale       = (ph_q == PH_ADDR);
  assign dstb      = (ph_q == PH_DATA);
  assign cmd_write = wr_q;
  assign drv_oe    = ale || (dstb && wr_q);

  generate
    if (AW >= DW) begin : g_addr_wide
      assign drv_data = ale ? addr_q[DW-1:0] : wdata_q;
    end else begin : g_addr_narrow
      assign drv_data = ale ? {{(DW-AW){1'b0}}, addr_q} : wdata_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      if (ph_q == PH_ADDR) begin
        ph_q <= PH_DATA;
      end else if (accept) begin
        ph_q <= PH_ADDR;
      end else begin
        ph_q <= PH_IDLE;
      end
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= dstb && !wr_q;
      if (dstb && !wr_q) rsp_rdata <= lines_in;
    end
  end

  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  assert_accept_to_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ale);
  assert_data_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> dstb);
  assert_data_needs_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dstb |-> $past(ale));
  assert_rsp_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(dstb) && !$past(cmd_write)));

endmodule

// File: rtl/muxbus_mem_target.sv
module muxbus_mem_target #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] lines_in,
  input  logic          ale,
  input  logic          dstb,
  input  logic          cmd_write,
  output logic          drv_oe,
  output logic [DW-1:0] drv_data
);
  import muxbus_pkg::*;

  localparam int IW    = AW - 1;
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] words [DEPTH];
  logic [IW-1:0] idx_q;
  logic          sel_q;
  logic          wr_q;
  logic          hit;
  logic          do_write;

  assign hit      = addr_is_memory(16'(lines_in), AW);
  assign do_write = dstb && sel_q && wr_q;
  assign drv_oe   = dstb && sel_q && !wr_q;
  assign drv_data = words[idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (ale) begin
      idx_q <= lines_in[IW-1:0];
      sel_q <= hit;
      wr_q  <= cmd_write;
    end
  end

  always_ff @(posedge clk) begin
    if (do_write) words[idx_q] <= lines_in;
  end

  assert_mem_drive_lower_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drv_oe |-> ($past(ale) && !$past(lines_in[AW-1])));

endmodule

// File: rtl/muxbus_io_target.sv
module muxbus_io_target #(
  parameter int DW      = 8,
  parameter int AW      = 8,
  parameter int IO_REGS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] lines_in,
  input  logic          ale,
  input  logic          dstb,
  input  logic          cmd_write,
  output logic          drv_oe,
  output logic [DW-1:0] drv_data
);
  import muxbus_pkg::*;

  localparam int XW = (IO_REGS > 1) ? $clog2(IO_REGS) : 1;

  logic [IO_REGS-1:0][DW-1:0] regs_q;
  logic [XW-1:0]              idx_q;
  logic                       sel_q;
  logic                       wr_q;
  logic                       hit;

  assign hit      = addr_is_io(16'(lines_in), AW, IO_REGS);
  assign drv_oe   = dstb && sel_q && !wr_q;
  assign drv_data = regs_q[idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (ale) begin
      idx_q <= lines_in[XW-1:0];
      sel_q <= hit;
      wr_q  <= cmd_write;
    end
  end

  generate
    for (genvar g = 0; g < IO_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          regs_q[g] <= '0;
        end else if (dstb && sel_q && wr_q && (idx_q == XW'(g))) begin
          regs_q[g] <= lines_in;
        end
      end
    end
  endgenerate

  assert_io_drive_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drv_oe |-> ($past(ale) && $past(lines_in[AW-1])));
  assert_unselected_keeps_regs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dstb && !sel_q) |=> $stable(regs_q));

endmodule

// File: rtl/muxbus_resolve.sv
module muxbus_resolve #(
  parameter int DW   = 8,
  parameter int NDRV = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NDRV-1:0]          oe,
  input  logic [NDRV-1:0][DW-1:0]  data,
  input  logic                     ale,
  input  logic                     dstb,
  output logic [DW-1:0]            lines
);
  logic [NDRV-1:0][DW-1:0] gated;

  generate
    for (genvar g = 0; g < NDRV; g++) begin : g_gate
      assign gated[g] = oe[g] ? data[g] : '0;
    end
  endgenerate

  always_comb begin
    lines = '0;
    for (int i = 0; i < NDRV; i++) lines = lines | gated[i];
  end

  assert_one_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oe));
  assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !dstb) |-> (lines == '0));
  assert_strobes_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && dstb));

endmodule

// File: rtl/muxbus_segment.sv
module muxbus_segment #(
  parameter int DW      = 8,
  parameter int AW      = 8,
  parameter int IO_REGS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [DW-1:0] bus_lines,
  output logic          bus_ale,
  output logic          bus_dstb,
  output logic          bus_cmd_write
);
  localparam int NDRV = 3;

  logic [NDRV-1:0]         drv_oe;
  logic [NDRV-1:0][DW-1:0] drv_data;
  logic [DW-1:0]           lines;
  logic                    ale;
  logic                    dstb;
  logic                    cmd_write;

  muxbus_master #(.DW(DW), .AW(AW)) u_master (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .lines_in(lines), .drv_oe(drv_oe[0]), .drv_data(drv_data[0]),
    .ale(ale), .dstb(dstb), .cmd_write(cmd_write)
  );

  muxbus_mem_target #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .lines_in(lines),
    .ale(ale), .dstb(dstb), .cmd_write(cmd_write),
    .drv_oe(drv_oe[1]), .drv_data(drv_data[1])
  );

  muxbus_io_target #(.DW(DW), .AW(AW), .IO_REGS(IO_REGS)) u_io (
    .clk(clk), .rst_n(rst_n), .lines_in(lines),
    .ale(ale), .dstb(dstb), .cmd_write(cmd_write),
    .drv_oe(drv_oe[2]), .drv_data(drv_data[2])
  );

  muxbus_resolve #(.DW(DW), .NDRV(NDRV)) u_resolve (
    .clk(clk), .rst_n(rst_n), .oe(drv_oe), .data(drv_data),
    .ale(ale), .dstb(dstb), .lines(lines)
  );

  assign bus_lines     = lines;
  assign bus_ale       = ale;
  assign bus_dstb      = dstb;
  assign bus_cmd_write = cmd_write;

endmodule

// File: tb/sim_muxbus_segment.sv
`timescale 1ns/1ps
module sim_muxbus_segment;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = 8'h00;
  logic [7:0] req_wdata = 8'h00;
  logic       req_ready, rsp_valid, bus_ale, bus_dstb, bus_cmd_write;
  logic [7:0] rsp_rdata, bus_lines;

  always #5 clk = ~clk;

  muxbus_segment u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_lines(bus_lines),
    .bus_ale(bus_ale), .bus_dstb(bus_dstb), .bus_cmd_write(bus_cmd_write)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Behavioural reference: phase number, current transfer, storage images.
  int   m_ph = 0;            // 0 idle, 1 address, 2 data
  bit   m_wr = 0;
  int   m_addr = 0;
  int   m_wd = 0;
  bit   m_rspv = 0;
  int   m_rspd = 0;
  int   mem_img [128];
  int   io_img [4];
  bit   written [128];

  function automatic int ref_read(input int a);
    if (a < 128) return mem_img[a];
    if (a - 128 < 4) return io_img[a - 128];
    return 0;
  endfunction

  function automatic string area_tag(input int a);
    if (a < 128) return "R5";
    if (a - 128 < 4) return "R6 R10";
    return "R7";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph   <= 0;
      m_rspv <= 0;
      m_wr   <= 0;
      for (int i = 0; i < 4; i++) io_img[i] <= 0;
    end else begin
      m_rspv <= 0;
      if (m_ph == 2) begin
        if (!m_wr) begin
          m_rspv <= 1;
          m_rspd <= ref_read(m_addr);
        end else if (m_addr < 128) begin
          mem_img[m_addr] <= m_wd;
        end else if (m_addr - 128 < 4) begin
          io_img[m_addr - 128] <= m_wd;
        end
      end
      if (m_ph == 1) m_ph <= 2;
      else if (req_valid) begin
        m_ph   <= 1;
        m_wr   <= req_write;
        m_addr <= int'(req_addr);
        m_wd   <= int'(req_wdata);
      end else m_ph <= 0;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h @%0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare every output on each falling edge once reset is released.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int eb;
      string bt;
      if (m_ph == 1) begin eb = m_addr; bt = "R2"; end
      else if (m_ph == 2 && m_wr) begin eb = m_wd; bt = "R4"; end
      else if (m_ph == 2) begin eb = ref_read(m_addr); bt = area_tag(m_addr); end
      else begin eb = 0; bt = "R8"; end
      check(bus_ale == (m_ph == 1), "R2", "address-valid", int'(bus_ale), int'(m_ph == 1));
      check(bus_dstb == (m_ph == 2), "R3", "data-valid", int'(bus_dstb), int'(m_ph == 2));
      check(req_ready == (m_ph != 1), "R9", "ready", int'(req_ready), int'(m_ph != 1));
      check(int'(bus_lines) == eb, bt, "bus lines", int'(bus_lines), eb);
      if (m_ph == 1)
        check(bus_cmd_write == m_wr, "R2", "command line", int'(bus_cmd_write), int'(m_wr));
      check(rsp_valid == m_rspv, "R5", "response valid", int'(rsp_valid), int'(m_rspv));
      if (m_rspv)
        check(int'(rsp_rdata) == m_rspd, area_tag(m_addr), "read data", int'(rsp_rdata), m_rspd);
    end
  end

  task automatic issue(input bit wr, input int a, input int d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = 8'(a);
    req_wdata = 8'(d);
    if (wr && a < 128) written[a] = 1;
    @(posedge clk);
  endtask

  task automatic gap(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired, run hung");
    finish_run();
  end

  initial begin : stim
    int lf;
    lf = 32'h1d5;
    // R1: state during reset and right after release
    repeat (3) @(negedge clk);
    check(!bus_ale && !bus_dstb, "R1", "strobes in reset", int'({bus_ale, bus_dstb}), 0);
    check(bus_lines == 8'h00, "R1", "lines in reset", int'(bus_lines), 0);
    check(req_ready && !rsp_valid, "R1", "ready/rsp in reset", int'({req_ready, rsp_valid}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_ale && req_ready, "R1", "after release", int'({bus_ale, req_ready}), 1);

    // R10: I/O registers read zero before any write (back to back)
    for (int i = 0; i < 4; i++) issue(0, 128 + i, 0);
    gap(3);

    // R5: memory edges and middle, written then read back
    issue(1, 8'h00, 8'h5A);
    issue(1, 8'h7F, 8'hC3);
    issue(1, 8'h35, 8'h11);
    gap(1);
    issue(0, 8'h00, 0);
    issue(0, 8'h7F, 0);
    gap(2);
    issue(0, 8'h35, 0);
    gap(2);

    // R6: I/O register and same-offset memory word are distinct
    issue(1, 8'h01, 8'h3C);
    issue(1, 8'h81, 8'hA5);
    issue(0, 8'h01, 0);
    issue(0, 8'h81, 0);
    gap(2);

    // R7: reserved upper addresses read zero and change nothing
    issue(1, 8'h84, 8'hFF);
    issue(1, 8'hFF, 8'hEE);
    issue(0, 8'h84, 0);
    issue(0, 8'hFF, 0);
    for (int i = 0; i < 4; i++) issue(0, 128 + i, 0);
    gap(2);

    // R9: request held through the address phase is taken only once
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h20; req_wdata = 8'h77;
    written[32] = 1;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    gap(2);
    issue(0, 8'h20, 0);
    gap(1);

    // Mixed random traffic with varied gaps
    for (int k = 0; k < 300; k++) begin
      int a, d;
      bit wr;
      lf = ((lf << 1) ^ ((lf >> 7) & 1) ^ ((lf >> 3) & 1) ^ k) & 32'hffff;
      a  = lf & 8'hff;
      d  = (lf >> 8) & 8'hff;
      wr = lf[4];
      if (!wr && a < 128 && !written[a]) wr = 1;
      if (a >= 128 && lf[5]) a = 128 + (a & 3);
      issue(wr, a, d);
      if (lf[6] && lf[9]) gap(lf & 3);
    end
    gap(4);
    finish_run();
  end

endmodule